// File: doc/BRIEF.md
# LPC Bus Target Cycle Decoder

This block is the target side of a Low Pin Count bus. It samples the frame strobe and the four-bit LAD bus on the bus clock and recognises single-byte I/O writes, I/O reads, ordinary memory reads and firmware reads. The two enable inputs decide which of the read kinds it accepts. Once a cycle's address, and for a write its data byte, have been collected, the block raises a valid level toward a local back end. It presents a 24-bit address, the write data byte and a write flag while valid is high.

While the back end has not acknowledged, the target keeps the host waiting with long-wait SYNC nibbles. The acknowledge may come from another clock domain, so it passes through a synchronizer whose depth is a parameter. After the acknowledge the target drives a ready SYNC. For a read it then returns the data byte as two nibbles. It finishes with one turnaround nibble and then releases LAD.

The controller is built around one state machine. ST_IDLE waits for a start. ST_CTYPE decodes the cycle type. ST_SELECT skips the firmware device-select nibble. ST_ADDR shifts in address nibbles. ST_SIZE skips the firmware size nibble. ST_WDATA collects write data. ST_HTAR covers the two host turnaround clocks. ST_WAIT drives long-wait SYNC. ST_READY drives ready SYNC. ST_RDATA drives read data. ST_PTAR drives the final turnaround.

The transitions are as follows. A start goes from any state to ST_CTYPE, or to ST_SELECT for a firmware start. A rejected type goes from ST_CTYPE back to ST_IDLE, and an accepted type goes from ST_CTYPE to ST_ADDR. ST_SELECT leads to ST_ADDR. ST_ADDR leads to ST_WDATA, ST_SIZE or ST_HTAR. ST_SIZE and ST_WDATA lead to ST_HTAR, and ST_HTAR leads to ST_WAIT. The synchronized acknowledge takes ST_WAIT to ST_READY. ST_READY leads to ST_RDATA for a read or to ST_PTAR for a write. ST_RDATA leads to ST_PTAR, and ST_PTAR leads to ST_IDLE. An abort goes from any state to ST_IDLE.

Top module: `lpc_target_decoder`

## Requirements
- R1: A clock edge with frame_n low and lad_in 0000 starts a cycle, and the next nibble with frame_n high is the type. The type codes are 0010 for an I/O write, 0000 for an I/O read and 0100 for a memory read. A start nibble of 1101 starts a firmware read instead.
- R2: An I/O cycle takes four address nibbles, most significant first. They appear on be_addr[15:0], and be_addr[23:16] reads zero. be_addr and be_wdata stay unchanged while be_valid is high.
- R3: A write takes two data nibbles, least significant first, into be_wdata. be_wr is 1 for a write and 0 for any read.
- R4: lad_oe stays low through the two host turnaround clocks, and the first nibble the target drives is always long-wait SYNC 0110.
- R5: From the clock after the second turnaround nibble until the acknowledge is seen, be_valid is high and LAD carries 0110 with lad_oe high. be_ack passes through ACK_STAGES flops, so the ready SYNC appears ACK_STAGES+1 clocks after be_ack rises.
- R6: After the acknowledge, the target drives 0000 with lad_oe high for one clock, and be_valid is already low during that clock.
- R7: For a read, the two clocks after the ready SYNC carry be_rdata as sampled with the acknowledge, low nibble first.
- R8: The last target clock of a cycle drives 1111 with lad_oe high. On the clock after it, lad_oe is low.
- R9: With en_read low, every read (I/O, memory and firmware) is ignored: be_valid and lad_oe stay low. Writes are still served.
- R10: A memory read with type 0100 is served only when en_memrd is high. It takes eight address nibbles, and the low 24 bits are kept. A firmware read needs only en_read. It takes one ignored select nibble, seven address nibbles with the low 24 bits kept, and one ignored size nibble.
- R11: frame_n low in the middle of a cycle aborts it on that edge. With a non-start nibble the block returns to idle, with lad_oe and be_valid low. With a start nibble a new cycle begins.
- R12: While rst_n is low, lad_oe, be_valid and be_wr are low, and the block restarts idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low bus reset, asynchronous |
| en_read | input | 1 | Accept read cycles of any kind |
| en_memrd | input | 1 | Also accept ordinary memory reads |
| frame_n | input | 1 | Active-low frame strobe from the host |
| lad_in | input | 4 | LAD value sampled from the bus |
| lad_out | output | 4 | LAD value the target drives |
| lad_oe | output | 1 | High while the target drives LAD |
| be_addr | output | ADDR_W | Address toward the back end |
| be_wr | output | 1 | 1 for a write cycle |
| be_wdata | output | DATA_W | Write data toward the back end |
| be_valid | output | 1 | Transfer pending, held until acknowledge is seen |
| be_rdata | input | DATA_W | Read data from the back end |
| be_ack | input | 1 | Back-end acknowledge, may be asynchronous |

## Verification
The bench builds the block with ACK_STAGES set to 3 rather than the default 2, and keeps the default 24-bit address and 8-bit data. The deeper synchronizer lengthens the long-wait stretch, so the bench can confirm that the ready SYNC comes exactly ACK_STAGES+1 clocks after the acknowledge rises and not at a fixed offset. The 24-bit address width lets eight-nibble memory addresses and seven-nibble firmware addresses show their truncation to the low 24 bits, next to the zero-extended 16-bit I/O address.

// File: rtl/lpcd_pkg.sv
package lpcd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTYPE,
        ST_SELECT,
        ST_ADDR,
        ST_SIZE,
        ST_WDATA,
        ST_HTAR,
        ST_WAIT,
        ST_READY,
        ST_RDATA,
        ST_PTAR
    } lpcd_state_e;

    // Nibble codes seen on or driven onto LAD
    localparam logic [3:0] NIB_START     = 4'b0000;
    localparam logic [3:0] NIB_START_FW  = 4'b1101;
    localparam logic [3:0] NIB_IO_RD     = 4'b0000;
    localparam logic [3:0] NIB_IO_WR     = 4'b0010;
    localparam logic [3:0] NIB_MEM_RD    = 4'b0100;
    localparam logic [3:0] NIB_WAIT_LONG = 4'b0110;
    localparam logic [3:0] NIB_READY     = 4'b0000;
    localparam logic [3:0] NIB_TURN      = 4'b1111;

    // Address nibble counts per cycle kind
    localparam int IO_ADDR_NIBS  = 4;
    localparam int MEM_ADDR_NIBS = 8;
    localparam int FW_ADDR_NIBS  = 7;
    localparam int HOST_TAR_CLKS = 2;

endpackage

// File: rtl/lpcd_ack_sync.sv
module lpcd_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_in,
    output logic ack_out
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign ack_out = ack_in;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q <= '0;
                end else if (STAGES == 1) begin
                    chain_q <= ack_in;
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], ack_in};
                end
            end
            assign ack_out = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/lpcd_type_decode.sv
module lpcd_type_decode
    import lpcd_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic [3:0]       ctype,
    input  logic             en_read,
    input  logic             en_memrd,
    output logic             accept,
    output logic             is_write,
    output logic [CNT_W-1:0] addr_nibs
);

    always_comb begin
        accept    = 1'b0;
        is_write  = 1'b0;
        addr_nibs = CNT_W'(IO_ADDR_NIBS);
        case (ctype)
            NIB_IO_WR: begin
                accept   = 1'b1;
                is_write = 1'b1;
            end
            NIB_IO_RD: begin
                accept = en_read;
            end
            NIB_MEM_RD: begin
                accept    = en_read && en_memrd;
                addr_nibs = CNT_W'(MEM_ADDR_NIBS);
            end
            default: begin
                accept = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lpcd_collect.sv
module lpcd_collect #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift_en,
    input  logic              load_en,
    input  logic [CNT_W-1:0]  load_idx,
    input  logic [3:0]        nib,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata
);

    localparam int DATA_NIBS = DATA_W / 4;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (clr) begin
            addr_q <= '0;
        end else if (shift_en) begin
            addr_q <= {addr_q[ADDR_W-5:0], nib};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wdata_q <= '0;
        end else begin
            for (int k = 0; k < DATA_NIBS; k++) begin
                if (load_en && load_idx == CNT_W'(k)) begin
                    wdata_q[4*k +: 4] <= nib;
                end
            end
        end
    end

    assign addr  = addr_q;
    assign wdata = wdata_q;

endmodule

// File: rtl/lpcd_lad_drive.sv
module lpcd_lad_drive
    import lpcd_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  lpcd_state_e       state,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [DATA_W-1:0] rd_buf,
    output logic [3:0]        lad_out,
    output logic              lad_oe,
    output logic              valid
);

    localparam int DATA_NIBS = DATA_W / 4;

    logic [3:0] rd_nib;

    always_comb begin
        rd_nib = '0;
        for (int k = 0; k < DATA_NIBS; k++) begin
            if (cnt == CNT_W'(k)) begin
                rd_nib = rd_buf[4*k +: 4];
            end
        end
    end

    always_comb begin
        lad_out = NIB_TURN;
        lad_oe  = 1'b0;
        valid   = 1'b0;
        unique case (state)
            ST_WAIT: begin
                lad_out = NIB_WAIT_LONG;
                lad_oe  = 1'b1;
                valid   = 1'b1;
            end
            ST_READY: begin
                lad_out = NIB_READY;
                lad_oe  = 1'b1;
            end
            ST_RDATA: begin
                lad_out = rd_nib;
                lad_oe  = 1'b1;
            end
            ST_PTAR: begin
                lad_out = NIB_TURN;
                lad_oe  = 1'b1;
            end
            default: begin
                lad_out = NIB_TURN;
                lad_oe  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lpc_target_decoder.sv
module lpc_target_decoder
    import lpcd_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int DATA_W     = 8,
    parameter int ACK_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_read,
    input  logic              en_memrd,
    input  logic              frame_n,
    input  logic [3:0]        lad_in,
    output logic [3:0]        lad_out,
    output logic              lad_oe,
    output logic [ADDR_W-1:0] be_addr,
    output logic              be_wr,
    output logic [DATA_W-1:0] be_wdata,
    output logic              be_valid,
    input  logic [DATA_W-1:0] be_rdata,
    input  logic              be_ack
);

    localparam int DATA_NIBS = DATA_W / 4;
    localparam int CNT_W     = $clog2(MEM_ADDR_NIBS + 1);

    lpcd_state_e       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              wr_q, wr_d;
    logic              fw_q, fw_d;
    logic [DATA_W-1:0] rd_q, rd_d;
    logic              clr_addr, shift_addr, load_data;
    logic              ack_s;
    logic              t_accept, t_write;
    logic [CNT_W-1:0]  t_nibs;

    lpcd_ack_sync #(.STAGES(ACK_STAGES)) u_ack_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack_in  (be_ack),
        .ack_out (ack_s)
    );

    lpcd_type_decode #(.CNT_W(CNT_W)) u_type_decode (
        .ctype     (lad_in),
        .en_read   (en_read),
        .en_memrd  (en_memrd),
        .accept    (t_accept),
        .is_write  (t_write),
        .addr_nibs (t_nibs)
    );

    lpcd_collect #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_collect (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_addr),
        .shift_en (shift_addr),
        .load_en  (load_data),
        .load_idx (cnt_q),
        .nib      (lad_in),
        .addr     (be_addr),
        .wdata    (be_wdata)
    );

    // Next-state decision
    always_comb begin
        state_d    = state_q;
        cnt_d      = cnt_q;
        wr_d       = wr_q;
        fw_d       = fw_q;
        rd_d       = rd_q;
        clr_addr   = 1'b0;
        shift_addr = 1'b0;
        load_data  = 1'b0;
        if (!frame_n) begin
            clr_addr = 1'b1;
            wr_d     = 1'b0;
            fw_d     = 1'b0;
            cnt_d    = '0;
            if (lad_in == NIB_START) begin
                state_d = ST_CTYPE;
            end else if (lad_in == NIB_START_FW && en_read) begin
                state_d = ST_SELECT;
                fw_d    = 1'b1;
            end else begin
                state_d = ST_IDLE;
            end
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_CTYPE: begin
                    if (t_accept) begin
                        state_d = ST_ADDR;
                        wr_d    = t_write;
                        cnt_d   = t_nibs - CNT_W'(1);
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
                ST_SELECT: begin
                    state_d = ST_ADDR;
                    cnt_d   = CNT_W'(FW_ADDR_NIBS - 1);
                end
                ST_ADDR: begin
                    shift_addr = 1'b1;
                    if (cnt_q == '0) begin
                        if (wr_q) begin
                            state_d = ST_WDATA;
                            cnt_d   = '0;
                        end else if (fw_q) begin
                            state_d = ST_SIZE;
                        end else begin
                            state_d = ST_HTAR;
                            cnt_d   = CNT_W'(HOST_TAR_CLKS - 1);
                        end
                    end else begin
                        cnt_d = cnt_q - CNT_W'(1);
                    end
                end
                ST_SIZE: begin
                    state_d = ST_HTAR;
                    cnt_d   = CNT_W'(HOST_TAR_CLKS - 1);
                end
                ST_WDATA: begin
                    load_data = 1'b1;
                    if (cnt_q == CNT_W'(DATA_NIBS - 1)) begin
                        state_d = ST_HTAR;
                        cnt_d   = CNT_W'(HOST_TAR_CLKS - 1);
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                ST_HTAR: begin
                    if (cnt_q == '0) begin
                        state_d = ST_WAIT;
                    end else begin
                        cnt_d = cnt_q - CNT_W'(1);
                    end
                end
                ST_WAIT: begin
                    if (ack_s) begin
                        state_d = ST_READY;
                        rd_d    = be_rdata;
                    end
                end
                ST_READY: begin
                    cnt_d   = '0;
                    state_d = wr_q ? ST_PTAR : ST_RDATA;
                end
                ST_RDATA: begin
                    if (cnt_q == CNT_W'(DATA_NIBS - 1)) begin
                        state_d = ST_PTAR;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                ST_PTAR: begin
                    state_d = ST_IDLE;
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            wr_q    <= 1'b0;
            fw_q    <= 1'b0;
            rd_q    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            wr_q    <= wr_d;
            fw_q    <= fw_d;
            rd_q    <= rd_d;
        end
    end

    // Outputs from the registered state
    lpcd_lad_drive #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_lad_drive (
        .state   (state_q),
        .cnt     (cnt_q),
        .rd_buf  (rd_q),
        .lad_out (lad_out),
        .lad_oe  (lad_oe),
        .valid   (be_valid)
    );

    assign be_wr = wr_q;

endmodule

// File: rtl/lpcd_checker.sv
module lpcd_checker #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_n,
    input logic [3:0]        lad_out,
    input logic              lad_oe,
    input logic [ADDR_W-1:0] be_addr,
    input logic              be_wr,
    input logic [DATA_W-1:0] be_wdata,
    input logic              be_valid
);

    AST_VALID_MEANS_LONG_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        be_valid |-> (lad_oe && lad_out == 4'b0110)); // R5

    AST_FIRST_DRIVE_IS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lad_oe) |-> (lad_out == 4'b0110)); // R4

    AST_READY_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(be_valid) && $past(frame_n)) |-> (lad_oe && lad_out == 4'b0000)); // R6

    AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (be_valid && $past(be_valid)) |-> ($stable(be_addr) && $stable(be_wdata))); // R2

    AST_WRITE_TAIL_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        (lad_oe && lad_out == 4'b0000 && $past(be_valid) && be_wr && frame_n)
        |=> (lad_oe && lad_out == 4'b1111)); // R8

    AST_WRITE_TAIL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (lad_oe && lad_out == 4'b1111 && $past(lad_oe) && $past(lad_out) == 4'b0000
         && be_wr && frame_n) |=> !lad_oe); // R8

endmodule

bind lpc_target_decoder lpcd_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lpcd_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_n  (frame_n),
    .lad_out  (lad_out),
    .lad_oe   (lad_oe),
    .be_addr  (be_addr),
    .be_wr    (be_wr),
    .be_wdata (be_wdata),
    .be_valid (be_valid)
);

// File: tb/lpc_target_decoder_bench.sv
module lpc_target_decoder_bench;

    localparam int CLK_PERIOD = 30;
    localparam int SYNC_N     = 3;
    localparam int WD_CYCLES  = 20000;

    typedef struct packed {
        logic [3:0]  start;
        logic [3:0]  ctype;
        logic [31:0] addr;
        logic [7:0]  wd;
        logic [7:0]  rd;
        logic [7:0]  delay;
    } vec_t;

    // start, type, address, write data, read data, ack delay
    localparam vec_t VECS [6] = '{
        '{4'h0, 4'h2, 32'h0000_0080, 8'hA5, 8'h00, 8'd3},
        '{4'h0, 4'h0, 32'h0000_03F8, 8'h00, 8'h5C, 8'd0},
        '{4'h0, 4'h2, 32'h0000_FFFF, 8'h0F, 8'h00, 8'd1},
        '{4'h0, 4'h4, 32'h1234_5678, 8'h00, 8'hC3, 8'd2},
        '{4'hD, 4'h0, 32'h00AB_CDEF, 8'h00, 8'h7E, 8'd4},
        '{4'h0, 4'h0, 32'h0000_0000, 8'h00, 8'hFF, 8'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_read = 1'b1;
    logic        en_memrd = 1'b1;
    logic        frame_n = 1'b1;
    logic [3:0]  lad_in = 4'hF;
    logic [3:0]  lad_out;
    logic        lad_oe;
    logic [23:0] be_addr;
    logic        be_wr;
    logic [7:0]  be_wdata;
    logic        be_valid;
    logic [7:0]  be_rdata = 8'h00;
    logic        be_ack = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit reported = 1'b0;

    lpc_target_decoder #(.ADDR_W(24), .DATA_W(8), .ACK_STAGES(SYNC_N)) u_lpc_target_decoder (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_read  (en_read),
        .en_memrd (en_memrd),
        .frame_n  (frame_n),
        .lad_in   (lad_in),
        .lad_out  (lad_out),
        .lad_oe   (lad_oe),
        .be_addr  (be_addr),
        .be_wr    (be_wr),
        .be_wdata (be_wdata),
        .be_valid (be_valid),
        .be_rdata (be_rdata),
        .be_ack   (be_ack)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        if (!reported) begin
            reported = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic put(input logic f, input logic [3:0] n);
        @(negedge clk);
        frame_n = f;
        lad_in  = n;
        @(posedge clk);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Feeds a cycle up to the end of host turnaround; leaves the bench at the posedge entering wait
    task automatic feed(input vec_t v, output int naddr);
        bit fw, wr;
        fw = (v.start == 4'hD);
        wr = !fw && (v.ctype == 4'h2);
        naddr = fw ? 7 : (v.ctype == 4'h4 ? 8 : 4);
        put(1'b0, v.start);
        put(1'b1, fw ? 4'h0 : v.ctype);
        for (int i = naddr - 1; i >= 0; i--) put(1'b1, v.addr[i*4 +: 4]);
        if (fw) put(1'b1, 4'h0);
        if (wr) begin
            put(1'b1, v.wd[3:0]);
            put(1'b1, v.wd[7:4]);
        end
        put(1'b1, 4'hF);
        @(negedge clk);
        chk("R4 oe in host turnaround", lad_oe, 0);
        lad_in = 4'hF;
        @(posedge clk);
    endtask

    task automatic bus_cycle(input vec_t v);
        int naddr;
        bit fw, wr;
        logic [23:0] exp_addr;
        fw = (v.start == 4'hD);
        wr = !fw && (v.ctype == 4'h2);
        feed(v, naddr);
        exp_addr = (naddr == 4) ? {8'h00, v.addr[15:0]} : v.addr[23:0];
        @(negedge clk);
        chk("R1 valid after decode", be_valid, 1);
        chk("R5 long wait nibble", {lad_oe, lad_out}, {1'b1, 4'b0110});
        chk("R2 address", be_addr, exp_addr);
        chk("R3 write flag", be_wr, wr);
        if (wr) chk("R3 write data", be_wdata, v.wd);
        be_rdata = v.rd;
        for (int d = 0; d < v.delay; d++) begin
            step();
            chk("R5 wait before ack", {be_valid, lad_oe, lad_out}, {2'b11, 4'b0110});
        end
        be_ack = 1'b1;
        for (int s = 0; s < SYNC_N; s++) begin
            step();
            chk("R5 wait during sync", {be_valid, lad_oe, lad_out}, {2'b11, 4'b0110});
        end
        step();
        chk("R6 ready sync", {be_valid, lad_oe, lad_out}, {2'b01, 4'b0000});
        be_ack = 1'b0;
        be_rdata = ~v.rd;
        if (!wr) begin
            step();
            chk("R7 read low nibble", {lad_oe, lad_out}, {1'b1, v.rd[3:0]});
            step();
            chk("R7 read high nibble", {lad_oe, lad_out}, {1'b1, v.rd[7:4]});
        end
        step();
        chk("R8 final turnaround", {lad_oe, lad_out}, {1'b1, 4'b1111});
        step();
        chk("R8 released", lad_oe, 0);
    endtask

    task automatic bus_ignored(input vec_t v, input string tag);
        int naddr;
        feed(v, naddr);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(tag, {be_valid, lad_oe}, 2'b00);
            @(posedge clk);
        end
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        int naddr;
        vec_t v;
        // R12 reset state
        repeat (3) @(negedge clk);
        chk("R12 reset outputs", {lad_oe, be_valid, be_wr}, 3'b000);
        rst_n = 1'b1;

        for (int i = 0; i < 6; i++) bus_cycle(VECS[i]);

        // R9: reads off, write still served
        en_read = 1'b0;
        bus_ignored(VECS[1], "R9 io read ignored");
        bus_ignored(VECS[4], "R9 firmware read ignored");
        bus_cycle(VECS[2]);
        en_read = 1'b1;

        // R10: memory reads gated separately, firmware reads unaffected
        en_memrd = 1'b0;
        bus_ignored(VECS[3], "R10 memory read ignored");
        bus_cycle('{4'hD, 4'h0, 32'h0F12_3456, 8'h00, 8'hA9, 8'd1});
        en_memrd = 1'b1;

        // R11: abort with non-start nibble, then a fresh cycle
        put(1'b0, 4'h0); put(1'b1, 4'h2); put(1'b1, 4'h1); put(1'b1, 4'h2);
        put(1'b0, 4'hF);
        @(negedge clk);
        chk("R11 idle after abort", {be_valid, lad_oe}, 2'b00);
        frame_n = 1'b1;
        // R11: abort by a new start mid-address
        put(1'b0, 4'h0); put(1'b1, 4'h2); put(1'b1, 4'h7);
        bus_cycle('{4'h0, 4'h2, 32'h0000_2E4C, 8'h3B, 8'h00, 8'd0});

        // R11: abort during long wait
        v = '{4'h0, 4'h2, 32'h0000_1111, 8'h22, 8'h00, 8'd0};
        feed(v, naddr);
        @(negedge clk);
        chk("R11 waiting before abort", be_valid, 1);
        frame_n = 1'b0;
        lad_in  = 4'hF;
        step();
        chk("R11 released on abort", {be_valid, lad_oe}, 2'b00);
        frame_n = 1'b1;

        // R12: reset during long wait, then a normal cycle
        feed(v, naddr);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R12 reset mid wait", {lad_oe, be_valid, be_wr}, 3'b000);
        step();
        rst_n = 1'b1;
        bus_cycle(VECS[1]);

        summary();
        $finish;
    end

endmodule